// File: doc/BRIEF.md
# Shared Attention Summary Register

Several drives share one control bus, and each drive keeps a single attention flag. This block models the summary view of those flags. It also models the logic inside each drive that sets a flag. A flag is set by a qualified error, by an operation-complete pulse or by a status-change pulse. A read at the summary address needs no drive select. Every drive places its own flag on its own bit of the 16-bit read bus and leaves the other bits undriven, so the controller sees one combined word.

A write to the summary address works by write-one-to-clear. A one at bit n clears the flag of drive n, and a zero leaves that flag alone. Software can therefore acknowledge exactly the flags it has read. A flag that became set after the read is not lost. A separate attention line reports whether any flag is set. A qualified error also raises this line in the cycle it occurs, before the flag register has updated.

Top module: `attn_summary_bus`

## Requirements
- R1: After reset, every attention flag is 0, the attention line is 0, and a summary read returns 0x0000.
- R2: While a read is presented at the summary address (register select 4), read-data bit n equals the flag of drive n. Bits from NUM_DRIVES up to 15 read as 0. Read data is 0x0000 when no summary read is presented.
- R3: A write at the summary address clears flag n in the next cycle when write-data bit n is 1. A flag whose write-data bit is 0 keeps its value, and a flag that is already 0 stays 0.
- R4: An operation-complete pulse or a status-change pulse for drive n sets flag n at the next clock edge.
- R5: An error pulse sets flag n only if drive n is idle (its busy input is low) or is rewinding. An error pulse while the drive is busy and not rewinding leaves the flag unchanged.
- R6: If a set event and a write-one clear reach the same flag in the same cycle, the flag ends at 1.
- R7: The attention line is high whenever any flag is 1. It is also high, in the same cycle, while any error pulse qualified under R5 is present.
- R8: A write to any register select other than 4 leaves all flags unchanged. A read of any other register select returns 0x0000.
- R9: Write-data bits from NUM_DRIVES up to 15 have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A bus access is presented this cycle |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accAddr | input | 5 | Register select |
| accWrData | input | 16 | Write data |
| accRdData | output | 16 | Combined read data from all drives |
| setErr | input | NUM_DRIVES | Per-drive error pulse |
| setDone | input | NUM_DRIVES | Per-drive operation-complete pulse |
| setStat | input | NUM_DRIVES | Per-drive status-change pulse |
| goBusy | input | NUM_DRIVES | Per-drive command-in-progress flag |
| rewinding | input | NUM_DRIVES | Per-drive rewind-in-progress flag |
| ataBits | output | NUM_DRIVES | Per-drive attention flags |
| attnLine | output | 1 | Shared attention line |

## Verification
A flag stuck in one drive shows up at the next summary read as a single wrong bit in that drive's position. It also shows up on the attention line within one cycle. A wrong clear or set priority shows up one cycle after the offending write, as a missing or stale bit. A bad qualification of errors shows up either as an attention line that stays low in the cycle of the error, or as a flag set during a busy transfer. The bench reads the summary word after each step, so every such fault appears at the ports one step after it occurs.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int ADDR_W   = 5;
  localparam int BUS_W    = 16;
  localparam logic [ADDR_W-1:0] SUM_ADDR = 5'd4;

  typedef struct packed {
    logic rdSum;
    logic wrSum;
  } accStrobes_t;
endpackage

// File: rtl/attn_ctrl.sv
module attn_ctrl
  import attn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output accStrobes_t       strb
);
  logic hitSum;

  assign hitSum     = accValid && (accAddr == SUM_ADDR);
  assign strb.rdSum = hitSum && !accWrite;
  assign strb.wrSum = hitSum && accWrite;

  // R2/R3: a single access never asks for both read and write
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdSum, strb.wrSum}));

  // R8: no strobe for any other register select
  assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr != SUM_ADDR) |-> !(strb.rdSum || strb.wrSum));
endmodule

// File: rtl/attn_drive_cell.sv
module attn_drive_cell
  import attn_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errIn,
  input  logic             doneIn,
  input  logic             statIn,
  input  logic             busyIn,
  input  logic             rewIn,
  input  logic             clrIn,
  input  logic             rdEn,
  output logic             ataQ,
  output logic             errNow,
  output logic [BUS_W-1:0] busOut
);
  logic setAny;

  assign errNow = errIn && (!busyIn || rewIn);
  assign setAny = errNow || doneIn || statIn;

  always_ff @(posedge clk) begin
    if (!rstN)       ataQ <= 1'b0;
    else if (setAny) ataQ <= 1'b1;
    else if (clrIn)  ataQ <= 1'b0;
  end

  // Each drive drives only its own bit position of the read bus
  always_comb begin
    busOut      = '0;
    busOut[IDX] = rdEn && ataQ;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (setAny && clrIn) |=> ataQ);

  assert_clear_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn && !setAny) |=> !ataQ);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!clrIn && !setAny) |=> $stable(ataQ));

  assert_busy_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errIn && busyIn && !rewIn && !doneIn && !statIn && !clrIn) |=> $stable(ataQ));

  assert_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn || statIn) |=> ataQ);
endmodule

// File: rtl/attn_datapath.sv
module attn_datapath
  import attn_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  accStrobes_t           strb,
  input  logic [BUS_W-1:0]      wrData,
  input  logic [NUM_DRIVES-1:0] setErr,
  input  logic [NUM_DRIVES-1:0] setDone,
  input  logic [NUM_DRIVES-1:0] setStat,
  input  logic [NUM_DRIVES-1:0] goBusy,
  input  logic [NUM_DRIVES-1:0] rewinding,
  output logic [BUS_W-1:0]      rdData,
  output logic [NUM_DRIVES-1:0] ataBits,
  output logic                  attnLine
);
  logic [NUM_DRIVES-1:0] clrVec;
  logic [NUM_DRIVES-1:0] errNowVec;
  logic [BUS_W-1:0]      cellBus [NUM_DRIVES];

  assign clrVec = strb.wrSum ? wrData[NUM_DRIVES-1:0] : '0;

  for (genvar n = 0; n < NUM_DRIVES; n++) begin : g_drive
    attn_drive_cell #(.IDX(n)) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .errIn  (setErr[n]),
      .doneIn (setDone[n]),
      .statIn (setStat[n]),
      .busyIn (goBusy[n]),
      .rewIn  (rewinding[n]),
      .clrIn  (clrVec[n]),
      .rdEn   (strb.rdSum),
      .ataQ   (ataBits[n]),
      .errNow (errNowVec[n]),
      .busOut (cellBus[n])
    );
  end

  // Wired-OR model of the shared read bus
  always_comb begin
    rdData = '0;
    for (int n = 0; n < NUM_DRIVES; n++) rdData = rdData | cellBus[n];
  end

  assign attnLine = (|ataBits) || (|errNowVec);

  assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdSum |-> (rdData == '0));

  assert_attn_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|ataBits) |-> attnLine);

  assert_reset_R1: assert property (@(posedge clk)
    $past(!rstN) |-> (ataBits == '0));
endmodule

// File: rtl/attn_summary_bus.sv
module attn_summary_bus
  import attn_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic [4:0]            accAddr,
  input  logic [15:0]           accWrData,
  output logic [15:0]           accRdData,
  input  logic [NUM_DRIVES-1:0] setErr,
  input  logic [NUM_DRIVES-1:0] setDone,
  input  logic [NUM_DRIVES-1:0] setStat,
  input  logic [NUM_DRIVES-1:0] goBusy,
  input  logic [NUM_DRIVES-1:0] rewinding,
  output logic [NUM_DRIVES-1:0] ataBits,
  output logic                  attnLine
);
  accStrobes_t strb;

  attn_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .strb     (strb)
  );

  attn_datapath #(.NUM_DRIVES(NUM_DRIVES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (accWrData),
    .setErr    (setErr),
    .setDone   (setDone),
    .setStat   (setStat),
    .goBusy    (goBusy),
    .rewinding (rewinding),
    .rdData    (accRdData),
    .ataBits   (ataBits),
    .attnLine  (attnLine)
  );
endmodule

// File: tb/test_attn_summary_bus.sv
module test_attn_summary_bus;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, accWrite;
  logic [4:0]  accAddr;
  logic [15:0] accWrData, accRdData;
  logic [7:0]  setErr, setDone, setStat, goBusy, rewinding, ataBits;
  logic        attnLine;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  attn_summary_bus i_attn_summary_bus (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accWrData(accWrData), .accRdData(accRdData),
    .setErr(setErr), .setDone(setDone), .setStat(setStat),
    .goBusy(goBusy), .rewinding(rewinding), .ataBits(ataBits),
    .attnLine(attnLine)
  );

  // {done, stat, wrEn, wrData, expected flags}
  localparam logic [40:0] VEC [0:7] = '{
    {8'h05, 8'h00, 1'b0, 16'h0000, 8'h05},  // R4 done
    {8'h00, 8'h80, 1'b0, 16'h0000, 8'h85},  // R4 status
    {8'h00, 8'h00, 1'b1, 16'h0001, 8'h84},  // R3 clear one
    {8'h00, 8'h00, 1'b1, 16'h0000, 8'h84},  // R3 zero no effect
    {8'h00, 8'h00, 1'b1, 16'hFF02, 8'h84},  // R3 clear of 0, R9 upper
    {8'h02, 8'h00, 1'b1, 16'h0002, 8'h86},  // R6 set wins
    {8'h00, 8'h00, 1'b1, 16'h00FF, 8'h00},  // R3 clear all
    {8'h00, 8'h18, 1'b0, 16'h0000, 8'h18}   // R4 status
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    accValid = 0; accWrite = 0; accAddr = 5'd4; accWrData = '0;
    setErr = '0; setDone = '0; setStat = '0; goBusy = '0; rewinding = '0;
  endtask

  task automatic stepEdge();
    @(posedge clk); #1;
  endtask

  task automatic readSum(input logic [7:0] exp, input string tag);
    accValid = 1; accWrite = 0; accAddr = 5'd4;
    #1;
    check(accRdData, {8'h00, exp}, tag);
    check({15'd0, attnLine}, {15'd0, |exp}, {tag, " attnLine R7"});
    accValid = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idleIn();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check({8'h00, ataBits}, 16'h0000, "R1 flags");
    readSum(8'h00, "R1 read");

    for (int i = 0; i < 8; i++) begin
      setDone   = VEC[i][40:33];
      setStat   = VEC[i][32:25];
      accValid  = VEC[i][24];
      accWrite  = VEC[i][24];
      accAddr   = 5'd4;
      accWrData = VEC[i][23:8];
      stepEdge();
      idleIn();
      check({8'h00, ataBits}, {8'h00, VEC[i][7:0]}, $sformatf("R3/R4/R6 vec%0d flags", i));
      readSum(VEC[i][7:0], $sformatf("R2 vec%0d read", i));
    end
    // state now 0x18

    // R8: write to another register select
    accValid = 1; accWrite = 1; accAddr = 5'd5; accWrData = 16'h00FF;
    stepEdge(); idleIn();
    check({8'h00, ataBits}, 16'h0018, "R8 other write");
    accValid = 1; accWrite = 0; accAddr = 5'd1; #1;
    check(accRdData, 16'h0000, "R8 other read");
    accValid = 0; #1;
    check(accRdData, 16'h0000, "R2 no read idle bus");

    // clear all
    accValid = 1; accWrite = 1; accAddr = 5'd4; accWrData = 16'hFFFF;
    stepEdge(); idleIn();
    readSum(8'h00, "R3 clear all");

    // R5: error while busy, not rewinding -> ignored
    setErr = 8'h08; goBusy = 8'h08; #1;
    check({15'd0, attnLine}, 16'h0000, "R7 busy error no line");
    stepEdge(); idleIn();
    readSum(8'h00, "R5 busy error ignored");

    // R5/R7: error while idle -> immediate line, flag next edge
    setErr = 8'h40; #1;
    check({15'd0, attnLine}, 16'h0001, "R7 immediate line");
    check({8'h00, ataBits}, 16'h0000, "R5 flag not yet set");
    stepEdge(); idleIn();
    readSum(8'h40, "R5 idle error sets");

    // R5: error while busy and rewinding -> sets
    setErr = 8'h01; goBusy = 8'h01; rewinding = 8'h01;
    stepEdge(); idleIn();
    readSum(8'h41, "R5 rewind error sets");

    // R6 with error source against clear
    setErr = 8'h40; accValid = 1; accWrite = 1; accAddr = 5'd4; accWrData = 16'h0041;
    stepEdge(); idleIn();
    readSum(8'h40, "R6 error beats clear");

    // R1: reset mid-run
    rstN = 0; stepEdge(); rstN = 1;
    check({8'h00, ataBits}, 16'h0000, "R1 reset clears");
    readSum(8'h00, "R1 read after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule